// File: doc/BRIEF.md
# Chain-Output Neighbour Transmitter

This block sits in one slot of a serial chain of design slots. It lets the slot pass a short message to the slot directly downstream. The chain is shifted four positions at a time and then latched. So the byte this slot drives arrives at the neighbour as two nibbles, one after the other. Each nibble holds three payload bits and, in its lowest bit, a clock bit. The clock bit is 0 in the first nibble and 1 in the second. Every pair of shifts therefore gives the neighbour two message bits, one end-of-message flag and one rising clock edge.

A chain-output start pulse loads a message and a step count. After that, each rising edge of the slot's own received clock bit moves the message on by one two-bit pair and uses up one step. The mode ends when the steps run out. The first and last slots of the chain do not send data. Instead they drive a fixed byte whose only set bit is bit 0, which gives the clock to their neighbour. A second mode streams seven-bit words toward the chain output, each followed by a last-word flag.

Top module: `chain_nbr_tx`

## Requirements
- R1: After reset, `tx_o` is 0 and both `chain_active_o` and `out_active_o` are 0.
- R2: While neither mode is active, `tx_o` stays 0 whatever `rx_clk_i` does.
- R3: In chain mode with role 2'b00 or 2'b11 (data slot), `tx_o` is {A,B,C,0,A,B,C,1} with A at bit 7. So bits 7..5 and 3..1 both carry A,B,C, bit 4 is 0 and bit 0 is 1.
- R4: Before the first advance, A and B are `chain_msg_i[MSG_W-1]` and `chain_msg_i[MSG_W-2]` as captured at start. Each rising edge of `rx_clk_i` moves on to the next lower pair.
- R5: C is 1 only on the step that carries the final pair, which is the lowest two message bits. Steps after the message is used up carry A=B=C=0.
- R6: Chain mode lasts exactly `chain_steps_i` rising edges of `rx_clk_i`. Then `chain_active_o` falls and `tx_o` returns to 0.
- R7: A chain start with a step count of 0 leaves chain mode inactive.
- R8: With role 2'b01 (first slot) or 2'b10 (last slot), `tx_o` is 8'h01 throughout chain mode.
- R9: In outside mode, `tx_o` is {word, last}. The 7-bit word at bits 7..1 is taken from `out_msg_i` most significant word first. The last flag at bit 0 is 1 only on the final word. Outside mode ends on the rising edge after the final word.
- R10: Start pulses that arrive while either mode is active are ignored. If both start pulses arrive together in idle, chain mode starts and outside mode does not.
- R11: Only a low-to-high change of `rx_clk_i` advances a mode. Holding it high, or letting it fall, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| role_i | input | 2 | Slot role: 00 data, 01 first, 10 last, 11 data |
| chain_go_i | input | 1 | One-cycle start pulse for chain mode |
| chain_steps_i | input | STEP_W | Number of steps for chain mode |
| chain_msg_i | input | MSG_W | Message sent to the neighbour, top pair first |
| out_go_i | input | 1 | One-cycle start pulse for outside mode |
| out_msg_i | input | 7*OUT_WORDS | Words for outside mode, top word first |
| rx_clk_i | input | 1 | Clock bit received by this slot |
| tx_o | output | 8 | Byte driven onto the slot's outputs |
| chain_active_o | output | 1 | Chain mode running |
| out_active_o | output | 1 | Outside mode running |

## Verification
Some rules can be checked on every cycle, and the assertions do so. In idle the output is 0. During chain mode the clock bits stay fixed and the two nibbles match. The end slots drive only the fixed byte. The two modes never run at once. A start from idle opens the right mode, and a zero count opens none. Other behaviour depends on history, and only the bench scenarios can show it. That covers the order in which pairs and words come out, the cycle where the end flag rises, the exact number of steps before the mode closes, and ignoring late starts and held clock levels.

// File: rtl/chain_nbr_pkg.sv
package chain_nbr_pkg;

   localparam int TX_W      = 8;
   localparam int NIB_W     = TX_W / 2;
   localparam int WORD_W    = TX_W - 1;

   typedef enum logic [1:0] {
      ROLE_DATA  = 2'b00,
      ROLE_FIRST = 2'b01,
      ROLE_LAST  = 2'b10,
      ROLE_DATA2 = 2'b11
   } role_e;

   typedef struct packed {
      logic a;
      logic b;
      logic c;
   } pair_t;

   localparam logic [TX_W-1:0] CLK_ONLY = 8'h01;

   function automatic logic [TX_W-1:0] chain_byte(input pair_t p);
      return {p.a, p.b, p.c, 1'b0, p.a, p.b, p.c, 1'b1};
   endfunction

endpackage

// File: rtl/cnt_rx_edge.sv
module cnt_rx_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_i,
   output logic rise_o
);

   logic lvl;
   logic lvl_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign lvl = rx_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] stg;
         always_ff @(posedge clk) begin
            if (!rst_n) stg <= '0;
            else        stg <= {stg[SYNC_STAGES-2:0], rx_i};
         end
         assign lvl = stg[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl;
   end

   assign rise_o = lvl & ~lvl_q;

endmodule

// File: rtl/cnt_chain_seq.sv
module cnt_chain_seq
   import chain_nbr_pkg::*;
#(
   parameter int MSG_W  = 16,
   parameter int STEP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [STEP_W-1:0] steps_i,
   input  logic [MSG_W-1:0]  msg_i,
   input  logic              adv_i,
   output logic              active_o,
   output pair_t             pair_o
);

   localparam int PAIRS  = MSG_W / 2;
   localparam int PIDX_W = $clog2(PAIRS + 1);
   localparam logic [PIDX_W-1:0] FINAL_IDX = PIDX_W'(PAIRS - 1);
   localparam logic [PIDX_W-1:0] DONE_IDX  = PIDX_W'(PAIRS);

   logic [STEP_W-1:0] steps_left;
   logic [MSG_W-1:0]  shreg;
   logic [PIDX_W-1:0] pidx;

   assign active_o = (steps_left != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         steps_left <= '0;
         shreg      <= '0;
         pidx       <= '0;
      end else if (load_i) begin
         steps_left <= steps_i;
         shreg      <= msg_i;
         pidx       <= '0;
      end else if (adv_i && active_o) begin
         steps_left <= steps_left - 1'b1;
         shreg      <= {shreg[MSG_W-3:0], 2'b00};
         if (pidx != DONE_IDX) pidx <= pidx + 1'b1;
      end
   end

   always_comb begin
      pair_o.a = shreg[MSG_W-1];
      pair_o.b = shreg[MSG_W-2];
      pair_o.c = (pidx == FINAL_IDX);
   end

endmodule

// File: rtl/cnt_out_seq.sv
module cnt_out_seq
   import chain_nbr_pkg::*;
#(
   parameter int OUT_WORDS = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load_i,
   input  logic [WORD_W*OUT_WORDS-1:0] msg_i,
   input  logic                        adv_i,
   output logic                        active_o,
   output logic [WORD_W-1:0]           word_o,
   output logic                        last_o
);

   localparam int OMSG_W = WORD_W * OUT_WORDS;
   localparam int WCNT_W = $clog2(OUT_WORDS + 1);

   logic [WCNT_W-1:0] words_left;
   logic [OMSG_W-1:0] shreg;

   assign active_o = (words_left != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         words_left <= '0;
         shreg      <= '0;
      end else if (load_i) begin
         words_left <= WCNT_W'(OUT_WORDS);
         shreg      <= msg_i;
      end else if (adv_i && active_o) begin
         words_left <= words_left - 1'b1;
         shreg      <= shreg << WORD_W;
      end
   end

   assign word_o = shreg[OMSG_W-1 -: WORD_W];
   assign last_o = (words_left == WCNT_W'(1));

endmodule

// File: rtl/chain_nbr_tx.sv
module chain_nbr_tx
   import chain_nbr_pkg::*;
#(
   parameter int MSG_W       = 16,
   parameter int STEP_W      = 8,
   parameter int OUT_WORDS   = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [1:0]                  role_i,
   input  logic                        chain_go_i,
   input  logic [STEP_W-1:0]           chain_steps_i,
   input  logic [MSG_W-1:0]            chain_msg_i,
   input  logic                        out_go_i,
   input  logic [WORD_W*OUT_WORDS-1:0] out_msg_i,
   input  logic                        rx_clk_i,
   output logic [TX_W-1:0]             tx_o,
   output logic                        chain_active_o,
   output logic                        out_active_o
);

   generate
      if (MSG_W < 4 || (MSG_W % 2) != 0) begin : g_bad_msg
         $error("MSG_W must be even and at least 4");
      end
      if (STEP_W < 1) begin : g_bad_step
         $error("STEP_W must be at least 1");
      end
      if (OUT_WORDS < 1) begin : g_bad_words
         $error("OUT_WORDS must be at least 1");
      end
      if (SYNC_STAGES == 1) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   logic        rise;
   logic        idle;
   logic        chain_load;
   logic        out_load;
   pair_t       pair;
   logic [WORD_W-1:0] oword;
   logic        olast;
   role_e       role;

   assign role       = role_e'(role_i);
   assign idle       = ~chain_active_o & ~out_active_o;
   assign chain_load = chain_go_i & idle;
   assign out_load   = out_go_i & idle & ~chain_go_i;

   cnt_rx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .rx_i   (rx_clk_i),
      .rise_o (rise)
   );

   cnt_chain_seq #(.MSG_W(MSG_W), .STEP_W(STEP_W)) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (chain_load),
      .steps_i  (chain_steps_i),
      .msg_i    (chain_msg_i),
      .adv_i    (rise),
      .active_o (chain_active_o),
      .pair_o   (pair)
   );

   cnt_out_seq #(.OUT_WORDS(OUT_WORDS)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (out_load),
      .msg_i    (out_msg_i),
      .adv_i    (rise),
      .active_o (out_active_o),
      .word_o   (oword),
      .last_o   (olast)
   );

   always_comb begin
      tx_o = '0;
      if (chain_active_o) begin
         if (role == ROLE_FIRST || role == ROLE_LAST) tx_o = CLK_ONLY;
         else                                         tx_o = chain_byte(pair);
      end else if (out_active_o) begin
         tx_o = {oword, olast};
      end
   end

endmodule

// File: rtl/chain_nbr_tx_chk.sv
module chain_nbr_tx_chk #(
   parameter int STEP_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        role_i,
   input logic              chain_go_i,
   input logic [STEP_W-1:0] chain_steps_i,
   input logic              out_go_i,
   input logic [7:0]        tx_o,
   input logic              chain_active_o,
   input logic              out_active_o
);

   logic idle;
   logic endslot;
   assign idle    = !chain_active_o && !out_active_o;
   assign endslot = (role_i == 2'b01) || (role_i == 2'b10);

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> tx_o == 8'h00); // R2

   AST_CLOCK_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (chain_active_o && !endslot) |-> (tx_o[4] == 1'b0 && tx_o[0] == 1'b1)); // R3

   AST_NIBBLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (chain_active_o && !endslot) |-> tx_o[7:5] == tx_o[3:1]); // R3

   AST_END_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (chain_active_o && endslot) |-> tx_o == 8'h01); // R8

   AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      !(chain_active_o && out_active_o)); // R10

   AST_CHAIN_START: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && chain_go_i && chain_steps_i != '0) |=> chain_active_o); // R6

   AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && chain_go_i && chain_steps_i == '0) |=> !chain_active_o && !out_active_o); // R7

   AST_OUT_START: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && out_go_i && !chain_go_i) |=> out_active_o); // R9

endmodule

bind chain_nbr_tx chain_nbr_tx_chk #(.STEP_W(STEP_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .role_i         (role_i),
   .chain_go_i     (chain_go_i),
   .chain_steps_i  (chain_steps_i),
   .out_go_i       (out_go_i),
   .tx_o           (tx_o),
   .chain_active_o (chain_active_o),
   .out_active_o   (out_active_o)
);

// File: tb/chain_nbr_tx_test.sv
module chain_nbr_tx_test;

   localparam int MSG_W = 16;
   localparam int STEP_W = 8;
   localparam int OUT_WORDS = 3;
   localparam int PAIRS = MSG_W / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] role = 2'b00;
   logic chain_go = 1'b0;
   logic [STEP_W-1:0] steps = '0;
   logic [MSG_W-1:0] cmsg = '0;
   logic out_go = 1'b0;
   logic [7*OUT_WORDS-1:0] omsg = '0;
   logic rx = 1'b0;
   logic [7:0] tx;
   logic cact, oact;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   chain_nbr_tx #(.MSG_W(MSG_W), .STEP_W(STEP_W), .OUT_WORDS(OUT_WORDS)) uut (
      .clk(clk), .rst_n(rst_n), .role_i(role), .chain_go_i(chain_go),
      .chain_steps_i(steps), .chain_msg_i(cmsg), .out_go_i(out_go),
      .out_msg_i(omsg), .rx_clk_i(rx), .tx_o(tx),
      .chain_active_o(cact), .out_active_o(oact));

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_chain(input logic [MSG_W-1:0] m, input int k);
      logic a, b, c;
      if (k < PAIRS) begin
         a = m[MSG_W-1-2*k];
         b = m[MSG_W-2-2*k];
         c = (k == PAIRS - 1);
      end else begin
         a = 1'b0; b = 1'b0; c = 1'b0;
      end
      return {a, b, c, 1'b0, a, b, c, 1'b1};
   endfunction

   task automatic rx_pulse();
      rx = 1'b1;
      repeat (4) @(negedge clk);
      rx = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic start_chain(input logic [STEP_W-1:0] n, input logic [MSG_W-1:0] m);
      steps = n; cmsg = m; chain_go = 1'b1;
      @(negedge clk);
      chain_go = 1'b0;
   endtask

   task automatic start_out(input logic [7*OUT_WORDS-1:0] m);
      omsg = m; out_go = 1'b1;
      @(negedge clk);
      out_go = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 tx", tx, 8'h00);
      check("R1 chain_active", {7'd0, cact}, 8'h00);
      check("R1 out_active", {7'd0, oact}, 8'h00);
   endtask

   task automatic t_idle();
      rx_pulse();
      rx = 1'b1;
      repeat (6) @(negedge clk);
      check("R2 idle tx", tx, 8'h00);
      rx = 1'b0;
      repeat (4) @(negedge clk);
      check("R2 idle tx after fall", tx, 8'h00);
   endtask

   task automatic t_chain_full(input logic [MSG_W-1:0] m);
      role = 2'b00;
      start_chain(8'(PAIRS + 2), m);
      for (int k = 0; k < PAIRS + 2; k++) begin
         check($sformatf("R3 R4 R5 step %0d", k), tx, exp_chain(m, k));
         check("R6 active during steps", {7'd0, cact}, 8'h01);
         rx_pulse();
      end
      check("R6 ends tx", tx, 8'h00);
      check("R6 ends active", {7'd0, cact}, 8'h00);
   endtask

   task automatic t_chain_short();
      logic [MSG_W-1:0] m = 16'hFFFF;
      role = 2'b11;
      start_chain(8'd3, m);
      for (int k = 0; k < 3; k++) begin
         check($sformatf("R5 short step %0d", k), tx, exp_chain(m, k));
         rx_pulse();
      end
      check("R6 short end", {7'd0, cact}, 8'h00);
   endtask

   task automatic t_zero();
      role = 2'b00;
      start_chain(8'd0, 16'hA5A5);
      check("R7 zero count active", {7'd0, cact}, 8'h00);
      check("R7 zero count tx", tx, 8'h00);
   endtask

   task automatic t_roles();
      role = 2'b01;
      start_chain(8'd2, 16'hFFFF);
      check("R8 first slot", tx, 8'h01);
      rx_pulse();
      check("R8 first slot step 1", tx, 8'h01);
      rx_pulse();
      role = 2'b10;
      start_chain(8'd1, 16'hFFFF);
      check("R8 last slot", tx, 8'h01);
      rx_pulse();
      check("R8 last slot end", {7'd0, cact}, 8'h00);
   endtask

   task automatic t_outside();
      logic [6:0] w [3];
      w[0] = 7'h55; w[1] = 7'h2A; w[2] = 7'h7F;
      start_out({w[0], w[1], w[2]});
      for (int k = 0; k < OUT_WORDS; k++) begin
         check($sformatf("R9 word %0d", k), tx, {w[k], (k == OUT_WORDS - 1)});
         rx_pulse();
      end
      check("R9 end active", {7'd0, oact}, 8'h00);
      check("R9 end tx", tx, 8'h00);
   endtask

   task automatic t_ignore();
      logic [MSG_W-1:0] m = 16'h39C6;
      role = 2'b00;
      start_chain(8'd4, m);
      rx_pulse();
      start_chain(8'd1, 16'hFFFF);
      start_out(21'h1FFFFF);
      check("R10 late start ignored", tx, exp_chain(m, 1));
      check("R10 no outside", {7'd0, oact}, 8'h00);
      repeat (3) rx_pulse();
      check("R10 original count kept", {7'd0, cact}, 8'h00);
      steps = 8'd2; cmsg = 16'hC000; omsg = 21'h1FFFFF;
      chain_go = 1'b1; out_go = 1'b1;
      @(negedge clk);
      chain_go = 1'b0; out_go = 1'b0;
      check("R10 both starts chain wins", {6'd0, cact, oact}, 8'h02);
      repeat (2) rx_pulse();
   endtask

   task automatic t_hold();
      logic [MSG_W-1:0] m = 16'h6E1B;
      role = 2'b00;
      start_chain(8'd3, m);
      rx = 1'b1;
      repeat (20) @(negedge clk);
      check("R11 first rise advances once", tx, exp_chain(m, 1));
      rx = 1'b0;
      repeat (20) @(negedge clk);
      check("R11 fall no advance", tx, exp_chain(m, 1));
      repeat (2) rx_pulse();
      check("R11 end", {7'd0, cact}, 8'h00);
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_idle();
      t_chain_full(16'hB4C9);
      t_chain_full(16'h4A63);
      t_chain_short();
      t_zero();
      t_roles();
      t_outside();
      t_ignore();
      t_hold();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule